// File: doc/BRIEF.md
# Selective-Load Condition Flag Word

This block keeps the processor's condition flags and its interrupt-enable bit together in one 8-bit word. Result registers report their own zero, negative, carry and overflow conditions on a shared 4-bit status bus. A register drives that bus only in a cycle in which it is loaded, incremented or decremented. When two registers are stepped together, the bus carries the bitwise OR of both reports. Registers that hold no results, such as the program counter, stack pointer, operand and instruction registers, are simply not connected to any bus source.

Four per-flag load strobes choose which flags take the bus value. The other flags keep their old values. The strobes come either from an instruction-class decode or, in direct mode, from outside. Dedicated inputs set or clear interrupt-enable. A clear-all input zeroes every condition flag at once. The whole byte is always visible, so it can be pushed to a stack. A restore write loads all eight bits from a saved byte, which brings the interrupt-enable state back when a nested service routine returns.

Top module: `cond_flag_word`

## Requirements
- R1: Bit layout is Z=bit0, N=bit1, C=bit2, V=bit3, interrupt-enable=bit4, and bits 7:5 are reserved but stored. While reset is active, and after it is released, all eight bits read 0 and `ie_out` reads 0.
- R2: The captured status is the OR of the 4-bit groups of the sources whose drive bit is 1. Source k uses bits [4k+3:4k], in the order Z, N, C, V. With no drive bit set, the status bus is zero.
- R3: In direct mode (`strobe_direct`=1), flag i takes status bit i on the next clock edge only when `strobe_in[i]`=1. Every flag whose strobe is 0 keeps its value.
- R4: In class mode (`strobe_direct`=0), strobes are produced only while `op_last`=1. For `op_class` the encodings are: 00 (ALU) loads Z, N, C and V; 01 (transfer) loads Z and N; 10 (increment/decrement) loads Z, N and V; 11 (branch) loads none. While `op_last`=0 no flag is loaded.
- R5: `clear_all` zeroes Z, N, C and V on the next edge and takes priority over the load strobes. It leaves interrupt-enable and the reserved bits unchanged.
- R6: `ie_set` sets bit4 and `ie_clear` clears it. When both are asserted, clear wins. Load strobes and `clear_all` never change bit4. `ie_out` always equals bit4.
- R7: `restore_wr` loads all eight bits from `restore_data` on the next edge. It takes priority over clear, strobes and the interrupt-enable inputs.
- R8: The reserved bits 7:5 change only through `restore_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_stat | input | 8 | Per-source status groups, source k at [4k+3:4k] |
| src_drive | input | 2 | Source k is loaded, incremented or decremented this cycle |
| op_class | input | 2 | Instruction class: 00 ALU, 01 transfer, 10 inc/dec, 11 branch |
| op_last | input | 1 | Last cycle of an instruction; enables class-derived strobes |
| strobe_direct | input | 1 | 1: use `strobe_in` instead of the class decode |
| strobe_in | input | 4 | Direct per-flag load strobes (Z, N, C, V order) |
| clear_all | input | 1 | Zero all condition flags |
| ie_set | input | 1 | Set interrupt-enable |
| ie_clear | input | 1 | Clear interrupt-enable |
| restore_wr | input | 1 | Load the whole word from `restore_data` |
| restore_data | input | 8 | Saved word to restore |
| flags_out | output | 8 | Current flag word (also the save path) |
| ie_out | output | 1 | Current interrupt-enable state |

## Verification
The assertions check several rules on every cycle: an idle status bus is zero, a cycle with no strobe leaves the flags unchanged, clear-all zeroes the flags, a restore reproduces the written byte, interrupt-enable set and clear behave as specified, and the reserved bits stay still without a restore. Only the bench scenarios can show that the OR-merge gives the right value with one and with two drivers. The same holds for the contents of each instruction-class strobe table, and for the outcome when restore, clear and interrupt-enable inputs collide in one cycle. Those scenarios also show that flags which were not selected survive a sequence of mixed-class instructions.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
   typedef enum logic [1:0] {
      OPC_ALU  = 2'd0,
      OPC_XFER = 2'd1,
      OPC_STEP = 2'd2,
      OPC_JUMP = 2'd3
   } opc_e;

   localparam int FLG_Z = 0;
   localparam int FLG_N = 1;
   localparam int FLG_C = 2;
   localparam int FLG_V = 3;
endpackage

// File: rtl/cfw_stat_merge.sv
module cfw_stat_merge #(
   parameter int NSRC  = 2,
   parameter int NFLAG = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NSRC*NFLAG-1:0]   src_stat,
   input  logic [NSRC-1:0]         src_drive,
   output logic [NFLAG-1:0]        bus
);
   logic [NFLAG-1:0] gated [NSRC];

   for (genvar k = 0; k < NSRC; k++) begin : g_src
      assign gated[k] = src_drive[k] ? src_stat[k*NFLAG +: NFLAG] : '0;
   end

   always_comb begin
      bus = '0;
      for (int k = 0; k < NSRC; k++) begin
         bus = bus | gated[k];
      end
   end

   // R2: undriven bus reads zero
   p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_drive == '0) |-> (bus == '0));
endmodule

// File: rtl/cfw_strobe_gen.sv
module cfw_strobe_gen
   import cfw_pkg::*;
#(
   parameter int NFLAG     = 4,
   parameter bit DIRECT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  opc_e             op_class,
   input  logic             op_last,
   input  logic             strobe_direct,
   input  logic [NFLAG-1:0] strobe_in,
   output logic [NFLAG-1:0] ld
);
   logic [NFLAG-1:0] cls_ld;

   always_comb begin
      cls_ld = '0;
      if (op_last) begin
         unique case (op_class)
            OPC_ALU: begin
               cls_ld[FLG_Z] = 1'b1;
               cls_ld[FLG_N] = 1'b1;
               cls_ld[FLG_C] = 1'b1;
               cls_ld[FLG_V] = 1'b1;
            end
            OPC_XFER: begin
               cls_ld[FLG_Z] = 1'b1;
               cls_ld[FLG_N] = 1'b1;
            end
            OPC_STEP: begin
               cls_ld[FLG_Z] = 1'b1;
               cls_ld[FLG_N] = 1'b1;
               cls_ld[FLG_V] = 1'b1;
            end
            default: cls_ld = '0;
         endcase
      end
   end

   if (DIRECT_EN) begin : g_direct
      assign ld = strobe_direct ? strobe_in : cls_ld;
   end else begin : g_class_only
      logic unused_dir;
      assign unused_dir = strobe_direct ^ (^strobe_in);
      assign ld = cls_ld;
   end

   // R4: branch class and non-final cycles request no load
   p_branch_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_direct && op_class == OPC_JUMP) |-> (ld == '0));
   p_not_last_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe_direct && !op_last) |-> (ld == '0));
endmodule

// File: rtl/cfw_store.sv
module cfw_store #(
   parameter int WIDTH  = 8,
   parameter int NFLAG  = 4,
   parameter int IE_POS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] bus,
   input  logic [NFLAG-1:0] ld,
   input  logic             clear_all,
   input  logic             ie_set,
   input  logic             ie_clear,
   input  logic             restore_wr,
   input  logic [WIDTH-1:0] restore_data,
   output logic [WIDTH-1:0] q
);
   localparam int RSV_LO = IE_POS + 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= '0;
      end else if (restore_wr) begin
         q <= restore_data;
      end else begin
         for (int i = 0; i < NFLAG; i++) begin
            if (clear_all)  q[i] <= 1'b0;
            else if (ld[i]) q[i] <= bus[i];
         end
         if (ie_clear)    q[IE_POS] <= 1'b0;
         else if (ie_set) q[IE_POS] <= 1'b1;
      end
   end

   // R3: flags hold when nothing selects them
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!restore_wr && !clear_all && ld == '0) |=> (q[NFLAG-1:0] == $past(q[NFLAG-1:0])));
   // R5: clear-all empties the condition flags
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_all && !restore_wr) |=> (q[NFLAG-1:0] == '0));
   // R5: clear-all alone keeps interrupt-enable
   p_clear_keeps_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!restore_wr && !ie_set && !ie_clear) |=> $stable(q[IE_POS]));
   // R6: interrupt-enable set and clear
   p_ie_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_set && !ie_clear && !restore_wr) |=> q[IE_POS]);
   p_ie_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_clear && !restore_wr) |=> !q[IE_POS]);
   // R7: restore writes the full word
   p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      restore_wr |=> (q == $past(restore_data)));

   if (RSV_LO < WIDTH) begin : g_rsv_chk
      // R8: reserved bits move only on restore
      p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !restore_wr |=> $stable(q[WIDTH-1:RSV_LO]));
   end
endmodule

// File: rtl/cond_flag_word.sv
module cond_flag_word
   import cfw_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int NFLAG     = 4,
   parameter int NSRC      = 2,
   parameter int IE_POS    = 4,
   parameter bit DIRECT_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSRC*NFLAG-1:0] src_stat,
   input  logic [NSRC-1:0]       src_drive,
   input  logic [1:0]            op_class,
   input  logic                  op_last,
   input  logic                  strobe_direct,
   input  logic [NFLAG-1:0]      strobe_in,
   input  logic                  clear_all,
   input  logic                  ie_set,
   input  logic                  ie_clear,
   input  logic                  restore_wr,
   input  logic [WIDTH-1:0]      restore_data,
   output logic [WIDTH-1:0]      flags_out,
   output logic                  ie_out
);
   if (NFLAG < 4) begin : g_bad_nflag
      $error("cond_flag_word: NFLAG must cover Z, N, C and V");
   end
   if (IE_POS < NFLAG || IE_POS >= WIDTH) begin : g_bad_iepos
      $error("cond_flag_word: IE_POS must lie above the flags and inside WIDTH");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("cond_flag_word: at least one status source is needed");
   end

   logic [NFLAG-1:0] stat_bus;
   logic [NFLAG-1:0] load_sel;
   logic [WIDTH-1:0] word_q;

   cfw_stat_merge #(.NSRC(NSRC), .NFLAG(NFLAG)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_stat  (src_stat),
      .src_drive (src_drive),
      .bus       (stat_bus)
   );

   cfw_strobe_gen #(.NFLAG(NFLAG), .DIRECT_EN(DIRECT_EN)) u_strobe (
      .clk           (clk),
      .rst_n         (rst_n),
      .op_class      (opc_e'(op_class)),
      .op_last       (op_last),
      .strobe_direct (strobe_direct),
      .strobe_in     (strobe_in),
      .ld            (load_sel)
   );

   cfw_store #(.WIDTH(WIDTH), .NFLAG(NFLAG), .IE_POS(IE_POS)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus          (stat_bus),
      .ld           (load_sel),
      .clear_all    (clear_all),
      .ie_set       (ie_set),
      .ie_clear     (ie_clear),
      .restore_wr   (restore_wr),
      .restore_data (restore_data),
      .q            (word_q)
   );

   assign flags_out = word_q;
   assign ie_out    = word_q[IE_POS];
endmodule

// File: tb/tb_cond_flag_word.sv
`timescale 1ns/1ps
module tb_cond_flag_word;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src_stat = '0;
   logic [1:0] src_drive = '0;
   logic [1:0] op_class = '0;
   logic       op_last = 1'b0;
   logic       strobe_direct = 1'b0;
   logic [3:0] strobe_in = '0;
   logic       clear_all = 1'b0;
   logic       ie_set = 1'b0;
   logic       ie_clear = 1'b0;
   logic       restore_wr = 1'b0;
   logic [7:0] restore_data = '0;
   logic [7:0] flags_out;
   logic       ie_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [7:0] model = '0;
   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   cond_flag_word dut (
      .clk(clk), .rst_n(rst_n), .src_stat(src_stat), .src_drive(src_drive),
      .op_class(op_class), .op_last(op_last), .strobe_direct(strobe_direct),
      .strobe_in(strobe_in), .clear_all(clear_all), .ie_set(ie_set),
      .ie_clear(ie_clear), .restore_wr(restore_wr), .restore_data(restore_data),
      .flags_out(flags_out), .ie_out(ie_out)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] class_strobes(input logic [1:0] c);
      case (c)
         2'b00:   return 4'b1111;
         2'b01:   return 4'b0011;
         2'b10:   return 4'b1011;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic cyc(input logic [3:0] a, input logic da, input logic [3:0] b,
                      input logic db, input logic [1:0] cls, input logic last,
                      input logic dir, input logic [3:0] ld, input logic clr,
                      input logic s, input logic c, input logic rw,
                      input logic [7:0] rd, input string tag);
      logic [3:0] bus, eff;
      @(negedge clk);
      src_stat = {b, a}; src_drive = {db, da};
      op_class = cls; op_last = last; strobe_direct = dir; strobe_in = ld;
      clear_all = clr; ie_set = s; ie_clear = c;
      restore_wr = rw; restore_data = rd;
      bus = (da ? a : 4'b0) | (db ? b : 4'b0);
      eff = dir ? ld : (last ? class_strobes(cls) : 4'b0);
      if (rw) begin
         model = rd;
      end else begin
         for (int i = 0; i < 4; i++) begin
            if (clr)         model[i] = 1'b0;
            else if (eff[i]) model[i] = bus[i];
         end
         if (c)      model[4] = 1'b0;
         else if (s) model[4] = 1'b1;
      end
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, flags_out, e);
            check({t, " ie_out R6"}, {7'b0, ie_out}, {7'b0, e[4]});
         end
      end
   end

   initial begin : watchdog
      #200000;
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      src_stat = 8'hFF; src_drive = 2'b11; strobe_direct = 1'b1; strobe_in = 4'hF;
      ie_set = 1'b1;
      repeat (3) @(posedge clk);
      #2;
      check("R1 reset value", flags_out, 8'h00);
      check("R1 reset ie_out", {7'b0, ie_out}, 8'h00);
      @(negedge clk);
      src_drive = '0; strobe_in = '0; ie_set = 1'b0;
      rst_n = 1'b1;
      // R1: stays zero right after release with no activity
      cyc(4'h0, 0, 4'h0, 0, 2'b11, 0, 1, 4'h0, 0, 0, 0, 0, 8'h00, "R1 after release");
      // R3: single strobe picks one flag
      cyc(4'hF, 1, 4'h0, 0, 2'b00, 0, 1, 4'b0001, 0, 0, 0, 0, 8'h00, "R3 Z-only strobe");
      // R2: undriven source B ignored
      cyc(4'h5, 1, 4'hA, 0, 2'b00, 0, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R2 one driver");
      // R2: two drivers are OR-merged
      cyc(4'h1, 1, 4'h4, 1, 2'b00, 0, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R2 two drivers OR");
      cyc(4'h8, 0, 4'h2, 1, 2'b00, 0, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R2 source B alone");
      // R2: idle bus loads zero
      cyc(4'hF, 0, 4'hF, 0, 2'b00, 0, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R2 idle bus");
      cyc(4'hF, 1, 4'h0, 0, 2'b00, 0, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R3 load all");
      // R3: C and V strobes with zero bus, Z,N kept
      cyc(4'h0, 1, 4'h0, 0, 2'b00, 0, 1, 4'b1100, 0, 0, 0, 0, 8'h00, "R3 C,V strobe");
      cyc(4'hF, 1, 4'h0, 0, 2'b00, 0, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R3 reload all");
      // R4: class table
      cyc(4'h0, 1, 4'h0, 0, 2'b01, 1, 0, 4'hF, 0, 0, 0, 0, 8'h00, "R4 transfer Z,N");
      cyc(4'h0, 1, 4'hF, 0, 2'b10, 1, 0, 4'h0, 0, 0, 0, 0, 8'h00, "R4 incdec Z,N,V");
      cyc(4'hA, 1, 4'h0, 0, 2'b00, 1, 0, 4'h0, 0, 0, 0, 0, 8'h00, "R4 alu all");
      cyc(4'h5, 1, 4'h0, 0, 2'b11, 1, 0, 4'hF, 0, 0, 0, 0, 8'h00, "R4 branch none");
      cyc(4'h5, 1, 4'h0, 0, 2'b00, 0, 0, 4'hF, 0, 0, 0, 0, 8'h00, "R4 not last cycle");
      cyc(4'h4, 1, 4'h1, 1, 2'b10, 1, 0, 4'h0, 0, 0, 0, 0, 8'h00, "R4 dual incdec OR");
      // R6: interrupt-enable
      cyc(4'h0, 0, 4'h0, 0, 2'b11, 0, 1, 4'h0, 0, 1, 0, 0, 8'h00, "R6 ie set");
      // R5: clear over strobes, IE kept
      cyc(4'hF, 1, 4'hF, 1, 2'b00, 0, 1, 4'hF, 1, 0, 0, 0, 8'h00, "R5 clear all");
      cyc(4'hF, 1, 4'h0, 0, 2'b00, 0, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R6 strobes keep ie");
      cyc(4'h0, 0, 4'h0, 0, 2'b11, 0, 1, 4'h0, 0, 1, 1, 0, 8'h00, "R6 clear wins");
      // R7: restore full word and priority
      cyc(4'h0, 0, 4'h0, 0, 2'b11, 0, 1, 4'h0, 0, 0, 0, 1, 8'hE7, "R7 restore");
      cyc(4'hF, 1, 4'h0, 0, 2'b00, 1, 0, 4'h0, 1, 0, 1, 1, 8'h35, "R7 restore priority");
      cyc(4'h0, 0, 4'h0, 0, 2'b11, 0, 1, 4'h0, 0, 0, 0, 1, 8'hFF, "R7 restore all ones");
      // R8: reserved bits untouched by clear, strobes and IE inputs
      cyc(4'h0, 1, 4'h0, 0, 2'b00, 0, 1, 4'hF, 1, 0, 1, 0, 8'h00, "R8 reserved kept");
      cyc(4'hF, 1, 4'h0, 0, 2'b00, 1, 0, 4'h0, 0, 1, 0, 0, 8'h00, "R8 reserved kept 2");
      cyc(4'h0, 0, 4'h0, 0, 2'b11, 0, 1, 4'h0, 0, 0, 0, 1, 8'h00, "R8 restore clears");
      cyc(4'h0, 0, 4'h0, 0, 2'b11, 0, 1, 4'h0, 0, 0, 0, 0, 8'h00, "R8 idle");
      repeat (3) @(posedge clk);
      #3;
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule